// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Completion

This block gathers level-sensitive interrupt requests from a set of numbered sources and presents them to a few handler contexts. Each context gets one interrupt line. Software programs a priority for every source, a per-context enable mask and a per-context threshold. A source can only raise a context's line when it is pending, enabled for that context, and its priority is strictly above that context's threshold.

A handler services a context through one claim/completion register. A read of that register returns the number of the best eligible source and takes the source out of the pending set. A later write of the same number tells the source's gateway that service is over, and the gateway may then accept a new request. Between claim and completion the source is held off, even if its request line stays high. Source number 0 is reserved. A claim value of 0 means that nothing is waiting.

Registers sit on a plain bus with word addresses. Read data is returned in the same cycle as the access, and writes and claim side effects take effect at the clock edge that closes the access.

Top module: `irq_hub`

## Requirements
- R1: After reset every interrupt line is low, every priority, enable bit and threshold reads zero, and a claim read returns 0.
- R2: The priority of source n (1..NSRC) is at word address n and holds the low PRIO_W bits of the written data, zero-extended on read. Word address 0 reads zero and ignores writes.
- R3: The enable bits of context c are at word address 0x800 + 0x20*c + n/32, with source n at bit n%32. Bit 0 of the first word (source 0) always reads 0.
- R4: The threshold of context c is at word address 0x80000 + 0x400*c and keeps the low PRIO_W bits. The claim/completion register is at the next word address.
- R5: A source is eligible for a context only when it is pending, enabled there, and its priority is strictly greater than the context threshold. A priority of 0 never interrupts.
- R6: A claim read returns the eligible source with the highest priority, and the lower source number when priorities are equal. It returns 0 when no source is eligible.
- R7: A claim clears the returned source's pending state. The context line is registered and drops in the cycle after the claim when no other source remains eligible.
- R8: A claimed source does not become pending again until it is completed, even with its request held high.
- R9: Writing a source number to the claim/completion register completes that source, so that a held request becomes pending again. A write naming a source that is not claimed has no effect.
- R10: With PRIO_W = 3, a threshold of 7 masks every source, and a threshold of 0 passes any source whose priority is not 0.
- R11: Reads of addresses that map to no register return zero.
- R12: Contexts are independent: a source enabled only in one context raises only that context's line and is claimed only through that context's register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level requests, bit n for source n (n = 1..NSRC) |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | NCTX | One interrupt line per context |

## Verification
The assertions assume a single bus, so no more than one claim read can happen in any cycle. They also assume that completion writes only name source numbers or values that the bench chose on purpose. The bench drives every access for exactly one clock edge and changes requests only away from the edge. It waits a fixed settle time after each request change, because the path from a request to the line passes through two registers. It completes every claimed source before it moves to the next scenario, except where the held-off state is the thing under test.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  // Word-address map (byte offsets divided by four)
  localparam int EN_BASE_W    = 'h800;
  localparam int EN_STRIDE_W  = 'h20;
  localparam int CTX_BASE_W   = 'h80000;
  localparam int CTX_STRIDE_W = 'h400;
  localparam int THR_OFS_W    = 0;
  localparam int CLAIM_OFS_W  = 1;

  function automatic int en_word_addr(input int ctx, input int word);
    return EN_BASE_W + EN_STRIDE_W * ctx + word;
  endfunction

  function automatic int thr_word_addr(input int ctx);
    return CTX_BASE_W + CTX_STRIDE_W * ctx + THR_OFS_W;
  endfunction

  function automatic int claim_word_addr(input int ctx);
    return CTX_BASE_W + CTX_STRIDE_W * ctx + CLAIM_OFS_W;
  endfunction

  // A candidate takes the lead only with a strictly higher priority, so a
  // scan in ascending source order leaves ties with the lower number.
  function automatic logic takes_lead(input int cand_p, input int best_p,
                                      input logic have_best);
    return !have_best || (cand_p > best_p);
  endfunction

  function automatic logic above_threshold(input int prio, input int thr);
    return prio > thr;
  endfunction

endpackage

// File: rtl/irq_hub_gateway.sv
module irq_hub_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic busy_o
);

  logic pend_q, busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (claim_i) begin
      pend_q <= 1'b0;
      busy_q <= 1'b1;
    end else begin
      if (complete_i && busy_q) busy_q <= 1'b0;
      if (req_i && !pend_q && !busy_q) pend_q <= 1'b1;
    end
  end

  assign pending_o = pend_q;
  assign busy_o    = busy_q;

endmodule

// File: rtl/irq_hub_arbiter.sv
module irq_hub_arbiter #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int IDW    = 5
) (
  input  logic [NSRC:0]             elig_i,
  input  logic [NSRC:0][PRIO_W-1:0] prio_i,
  output logic [IDW-1:0]            best_id_o,
  output logic [PRIO_W-1:0]         best_prio_o,
  output logic                      found_o
);

  always_comb begin
    best_id_o   = '0;
    best_prio_o = '0;
    found_o     = 1'b0;
    for (int s = 0; s <= NSRC; s++) begin
      if (elig_i[s] &&
          irq_hub_pkg::takes_lead(int'(prio_i[s]), int'(best_prio_o), found_o)) begin
        best_id_o   = IDW'(s);
        best_prio_o = prio_i[s];
        found_o     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_i,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCTX-1:0]   irq_o
);

  localparam int IDW = $clog2(NSRC + 1);
  localparam int NW  = (NSRC + 32) / 32;

  logic bus_rd, bus_wr;
  assign bus_rd = bus_sel && !bus_we;
  assign bus_wr = bus_sel && bus_we;

  // Configuration state
  logic [NSRC:0][PRIO_W-1:0] prio_q;
  logic [NCTX-1:0][NSRC:0]   en_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;

  // Event wires shared with the checker
  logic [NSRC:0]           pend_w, busy_w;
  logic [NSRC:0]           claim_vec, complete_vec;
  logic [NCTX-1:0][NSRC:0] elig;
  logic [NCTX-1:0]         any_elig, found_w, claim_rd, complete_wr;
  logic [NCTX-1:0][IDW-1:0]    best_id;
  logic [NCTX-1:0][PRIO_W-1:0] best_prio_w;
  logic [NCTX-1:0]         irq_q;

  assign pend_w[0] = 1'b0;
  assign busy_w[0] = 1'b0;

  // Source gateways
  generate
    for (genvar s = 1; s <= NSRC; s++) begin : g_src
      irq_hub_gateway u_gw (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (src_i[s]),
        .claim_i    (claim_vec[s]),
        .complete_i (complete_vec[s]),
        .pending_o  (pend_w[s]),
        .busy_o     (busy_w[s])
      );
    end
  endgenerate

  // Per-context eligibility, arbitration and claim decode
  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      for (genvar s = 0; s <= NSRC; s++) begin : g_el
        assign elig[c][s] = pend_w[s] && en_q[c][s] &&
          irq_hub_pkg::above_threshold(int'(prio_q[s]), int'(thr_q[c]));
      end
      assign any_elig[c] = |elig[c];

      irq_hub_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
        .elig_i      (elig[c]),
        .prio_i      (prio_q),
        .best_id_o   (best_id[c]),
        .best_prio_o (best_prio_w[c]),
        .found_o     (found_w[c])
      );

      assign claim_rd[c]    = bus_rd &&
        (bus_addr == ADDR_W'(irq_hub_pkg::claim_word_addr(c)));
      assign complete_wr[c] = bus_wr &&
        (bus_addr == ADDR_W'(irq_hub_pkg::claim_word_addr(c)));
    end
  endgenerate

  // Claim and completion fan-out to the gateways
  always_comb begin
    claim_vec    = '0;
    complete_vec = '0;
    for (int s = 1; s <= NSRC; s++) begin
      for (int c = 0; c < NCTX; c++) begin
        if (claim_rd[c] && found_w[c] && (best_id[c] == IDW'(s)))
          claim_vec[s] = 1'b1;
        if (complete_wr[c] && (bus_wdata == 32'(s)))
          complete_vec[s] = 1'b1;
      end
    end
  end

  // Padded enable words for word-wise access
  logic [NCTX-1:0][NW*32-1:0] en_pad, en_nxt;

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      en_pad[c] = (NW*32)'(en_q[c]);
      en_nxt[c] = en_pad[c];
      for (int w = 0; w < NW; w++) begin
        if (bus_wr && (bus_addr == ADDR_W'(irq_hub_pkg::en_word_addr(c, w))))
          en_nxt[c][w*32 +: 32] = bus_wdata;
      end
      en_nxt[c][0] = 1'b0;
    end
  end

  // Register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else begin
      for (int s = 1; s <= NSRC; s++) begin
        if (bus_wr && (bus_addr == ADDR_W'(s)))
          prio_q[s] <= bus_wdata[PRIO_W-1:0];
      end
      for (int c = 0; c < NCTX; c++) begin
        en_q[c] <= en_nxt[c][NSRC:0];
        if (bus_wr && (bus_addr == ADDR_W'(irq_hub_pkg::thr_word_addr(c))))
          thr_q[c] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end

  // Registered interrupt lines; the claimed source is removed in advance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else begin
      for (int c = 0; c < NCTX; c++)
        irq_q[c] <= |(elig[c] & ~claim_vec);
    end
  end
  assign irq_o = irq_q;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (bus_addr == ADDR_W'(s)) bus_rdata = 32'(prio_q[s]);
    end
    for (int c = 0; c < NCTX; c++) begin
      for (int w = 0; w < NW; w++) begin
        if (bus_addr == ADDR_W'(irq_hub_pkg::en_word_addr(c, w)))
          bus_rdata = en_pad[c][w*32 +: 32];
      end
      if (bus_addr == ADDR_W'(irq_hub_pkg::thr_word_addr(c)))
        bus_rdata = 32'(thr_q[c]);
      if (bus_addr == ADDR_W'(irq_hub_pkg::claim_word_addr(c)))
        bus_rdata = 32'(best_id[c]);
    end
  end

endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NCTX-1:0]             irq_o,
  input logic [NSRC:0]               pend,
  input logic [NSRC:0]               busy,
  input logic [NSRC:0]               claim_vec,
  input logic [NCTX-1:0]             found,
  input logic [NCTX-1:0][PRIO_W-1:0] sel_prio,
  input logic [NCTX-1:0][PRIO_W-1:0] thr,
  input logic [NCTX-1:0]             any_elig
);

  AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec)); // R6

  generate
    for (genvar s = 1; s <= NSRC; s++) begin : g_s
      AST_CLAIM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        claim_vec[s] |=> (busy[s] && !pend[s])); // R7
      AST_HELD_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        busy[s] |-> !pend[s]); // R8
      AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy[s] && !claim_vec[s]) |=> !busy[s]); // R9
    end
    for (genvar c = 0; c < NCTX; c++) begin : g_c
      AST_WINNER_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
        found[c] |-> (sel_prio[c] > thr[c])); // R5
      AST_LINE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[c]) |-> $past(any_elig[c])); // R7
    end
  endgenerate

endmodule

bind irq_hub irq_hub_checker #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .pend      (pend_w),
  .busy      (busy_w),
  .claim_vec (claim_vec),
  .found     (found_w),
  .sel_prio  (best_prio_w),
  .thr       (thr_q),
  .any_elig  (any_elig)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;

  localparam int NSRC = 31;
  localparam int NCTX = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NSRC:1] src = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCTX-1:0] irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  irq_hub u_irq_hub (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // Address map restated from the requirements
  function automatic logic [23:0] a_prio(input int n); return 24'(n); endfunction
  function automatic logic [23:0] a_en(input int c, input int w); return 24'('h800 + 'h20*c + w); endfunction
  function automatic logic [23:0] a_thr(input int c); return 24'('h80000 + 'h400*c); endfunction
  function automatic logic [23:0] a_clm(input int c); return 24'('h80000 + 'h400*c + 1); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq lines", 32'(irq), 0);
    rd(a_clm(0), d); check("R1 claim empty", d, 0);
    rd(a_prio(4), d); check("R1 priority", d, 0);
    rd(a_en(1, 0), d); check("R1 enable", d, 0);
    rd(a_thr(1), d); check("R1 threshold", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(a_prio(5), 32'hFF); rd(a_prio(5), d); check("R2 priority width", d, 7);
    wr(a_prio(0), 32'h5); rd(a_prio(0), d); check("R2 source 0", d, 0);
    wr(a_en(0, 0), 32'hFFFF_FFFF); rd(a_en(0, 0), d); check("R3 enable bit0", d, 32'hFFFF_FFFE);
    wr(a_en(0, 0), 0);
    wr(a_thr(1), 32'h1D); rd(a_thr(1), d); check("R4 threshold width", d, 5);
    wr(a_thr(1), 0);
    rd(24'h700, d); check("R11 hole", d, 0);
    rd(a_en(0, 1), d); check("R11 missing word", d, 0);
    rd(a_thr(0) + 2, d); check("R11 ctx hole", d, 0);
  endtask

  task automatic t_arbitrate();
    logic [31:0] d;
    wr(a_prio(3), 2); wr(a_prio(5), 5); wr(a_prio(9), 5);
    wr(a_en(0, 0), (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 9));
    wr(a_thr(0), 0);
    @(negedge clk); src[3] = 1; src[5] = 1; src[9] = 1;
    settle(3);
    check("R5 line up", 32'(irq[0]), 1);
    check("R12 other ctx", 32'(irq[1]), 0);
    rd(a_clm(0), d); check("R6 tie low id", d, 5);
    rd(a_clm(0), d); check("R6 next", d, 9);
    check("R7 line stays", 32'(irq[0]), 1);
    rd(a_clm(0), d); check("R6 lowest prio", d, 3);
    check("R7 line drops", 32'(irq[0]), 0);
    rd(a_clm(0), d); check("R6 none left", d, 0);
    settle(4);
    rd(a_clm(0), d); check("R8 held off", d, 0);
    wr(a_clm(0), 6); settle(4);
    rd(a_clm(0), d); check("R9 stray completion", d, 0);
    check("R9 stray line", 32'(irq[0]), 0);
    wr(a_clm(0), 9); settle(3);
    check("R9 rearm line", 32'(irq[0]), 1);
    rd(a_clm(0), d); check("R9 rearm id", d, 9);
    @(negedge clk); src = '0;
    wr(a_clm(0), 3); wr(a_clm(0), 5); wr(a_clm(0), 9);
    settle(3);
    check("R7 idle", 32'(irq[0]), 0);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    wr(a_en(0, 0), 32'd1 << 5); wr(a_prio(5), 5); wr(a_thr(0), 5);
    @(negedge clk); src[5] = 1;
    settle(3);
    check("R5 equal masked", 32'(irq[0]), 0);
    rd(a_clm(0), d); check("R5 equal claim", d, 0);
    wr(a_thr(0), 4); settle(2);
    check("R5 above passes", 32'(irq[0]), 1);
    rd(a_clm(0), d); check("R5 claim", d, 5);
    wr(a_prio(5), 7); wr(a_thr(0), 7); wr(a_clm(0), 5); settle(3);
    check("R10 thr 7 masks", 32'(irq[0]), 0);
    wr(a_prio(5), 1); wr(a_thr(0), 0); settle(2);
    check("R10 thr 0 passes", 32'(irq[0]), 1);
    rd(a_clm(0), d); check("R10 claim", d, 5);
    wr(a_prio(5), 0); wr(a_clm(0), 5); settle(3);
    check("R5 prio 0 line", 32'(irq[0]), 0);
    rd(a_clm(0), d); check("R5 prio 0 claim", d, 0);
    @(negedge clk); src[5] = 0;
    wr(a_en(0, 0), 0);
  endtask

  task automatic t_contexts();
    logic [31:0] d;
    wr(a_en(1, 0), 32'd1 << 9); wr(a_thr(1), 0); wr(a_prio(9), 3);
    @(negedge clk); src[9] = 1;
    settle(3);
    check("R12 ctx1 line", 32'(irq[1]), 1);
    check("R12 ctx0 quiet", 32'(irq[0]), 0);
    rd(a_clm(0), d); check("R12 ctx0 claim", d, 0);
    rd(a_clm(1), d); check("R12 ctx1 claim", d, 9);
    check("R7 ctx1 drop", 32'(irq[1]), 0);
    @(negedge clk); src[9] = 0;
    wr(a_clm(1), 9);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_arbitrate();
    t_threshold();
    t_contexts();
    settle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule